// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 128 interrupt request sources, each with its own 4-bit priority, and tells the processor which one to serve. A registered arbiter picks the pending source with the highest level that is strictly above the current priority. It presents that source's 9-bit vector together with a request line. Within one level the lowest source index wins.

The first eight sources are raised and cleared by software through a small register interface. The remaining sources come from hardware request lines. When the processor acknowledges a request, the controller saves the current priority in a one-deep holding register and raises the mask to the level being served, so that only higher levels can preempt. An end-of-interrupt write puts the saved value back. Software can also write the current priority directly, which lets tasks that share a resource raise a common ceiling and stop preempting one another. A separate non-maskable input reaches its output without passing through arbitration or masking.

Register map, with the address `ADDR_W` bits wide:

| Address | Write | Read |
|---|---|---|
| 0 | current priority | current priority |
| 1 | end of interrupt | saved priority |
| 2 | set software sources | software source flags |
| 3 | clear software sources | 0 |
| 256+i | priority of source i | priority of source i |

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, irq_out and vec_out are 0, and the current priority, saved priority, every source priority and every software flag read as 0.
- R2: A source is forwarded only when it is pending and its priority is strictly greater than the current priority. A source at priority 0 is never forwarded. When nothing qualifies, irq_out is 0 and vec_out is 0.
- R3: Among qualifying sources the highest priority wins. Among sources of equal priority the lowest index wins.
- R4: vec_out equals the winning source index, zero-extended to 9 bits.
- R5: The outputs are registered. A change on hw_req before clock edge k shows on irq_out/vec_out after edge k. A register write taken at edge k shows after edge k+1.
- R6: Sources 0..7 are software flags. A write to address 2 sets every flag whose data bit is 1. A write to address 3 clears every flag whose data bit is 1. Zero bits leave flags unchanged. hw_req[j] drives source j+8.
- R7: A write to address 0 loads data bits [3:0] into the current priority, and the value can be read back at address 0.
- R8: If ack is high while irq_out is high, the current priority moves to the saved register and the current priority becomes the level of the presented source. An ack while irq_out is low has no effect.
- R9: A write to address 1 (end of interrupt) copies the saved priority back into the current priority.
- R10: When an accepted ack and a write to address 0 or 1 fall in the same cycle, the ack takes effect and the write is discarded.
- R11: A write to address 256+i stores data bits [3:0] as the priority of source i, and the value can be read back at that address.
- R12: nmi_out follows nmi_in in the same cycle, whatever the priorities, mask or pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational register read data |
| hw_req | input | NUM_SRC-NUM_SW | Level hardware requests for sources NUM_SW and up |
| ack | input | 1 | Processor acknowledge of the presented request |
| nmi_in | input | 1 | Non-maskable request input |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | VEC_W | Vector of the presented source |
| nmi_out | output | 1 | Non-maskable request to the processor |

## Verification
The processor acknowledge and a software write to the current priority or end-of-interrupt address both update the current priority register, so they can collide in one cycle. The bench raises ack in the same cycle as a mask write, and again in the same cycle as an end-of-interrupt write, while a request is presented. In both cases it reads back the current priority and expects the served level rather than the written or saved value. Sweeps over pending patterns and mask values are checked against a priority search computed in the bench.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared register-select type and fixed register offsets for the interrupt
// controller. Assumes the priority table sits at the top half of the address
// space (most significant address bit set).
package irqc_pkg;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_CUR   = 3'd1,
        SEL_EOI   = 3'd2,
        SEL_SWSET = 3'd3,
        SEL_SWCLR = 3'd4,
        SEL_PRIO  = 3'd5
    } regsel_e;

    localparam int OFS_CUR   = 0;
    localparam int OFS_EOI   = 1;
    localparam int OFS_SWSET = 2;
    localparam int OFS_SWCLR = 3;

endpackage

// File: rtl/irqc_regs.sv
// Module irqc_regs
// Holds the per-source priority table, the software request flags, the
// current priority and its one-deep saved copy. Decodes register writes and
// serves combinational reads. An accepted acknowledge outranks any write to
// the current or end-of-interrupt addresses in the same cycle.
// Assumes DATA_W >= NUM_SW and DATA_W >= PRIO_W, and 2**(ADDR_W-1) >= NUM_SRC.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int NUM_SW  = 8,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 9,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      ack_take,
    input  logic [PRIO_W-1:0]         ack_lvl,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [NUM_SW-1:0]         sw_flags,
    output logic [PRIO_W-1:0]         cur_prio
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    regsel_e             wsel;
    regsel_e             rsel;
    logic [IDX_W-1:0]    widx;
    logic [IDX_W-1:0]    ridx;
    logic [PRIO_W-1:0]   prio_q [NUM_SRC];
    logic [PRIO_W-1:0]   cur_q;
    logic [PRIO_W-1:0]   saved_q;
    logic [NUM_SW-1:0]   sw_q;
    logic [NUM_SW-1:0]   set_mask;
    logic [NUM_SW-1:0]   clr_mask;

    // Map an address onto the register it selects.
    function automatic regsel_e decode(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1]) begin
            if (int'(a[ADDR_W-2:0]) < NUM_SRC) return SEL_PRIO;
            return SEL_NONE;
        end
        if (int'(a) == OFS_CUR)   return SEL_CUR;
        if (int'(a) == OFS_EOI)   return SEL_EOI;
        if (int'(a) == OFS_SWSET) return SEL_SWSET;
        if (int'(a) == OFS_SWCLR) return SEL_SWCLR;
        return SEL_NONE;
    endfunction

    // Decode both access addresses.
    always_comb begin
        wsel = decode(wr_addr);
        rsel = decode(rd_addr);
        widx = wr_addr[IDX_W-1:0];
        ridx = rd_addr[IDX_W-1:0];
    end

    // Per-source priority registers, one per source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[s] <= '0;
            else if (wr_en && wsel == SEL_PRIO && widx == IDX_W'(s))
                prio_q[s] <= wr_data[PRIO_W-1:0];
        end
        assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
    end

    // Set and clear masks for the software request flags.
    always_comb begin
        set_mask = (wr_en && wsel == SEL_SWSET) ? wr_data[NUM_SW-1:0] : '0;
        clr_mask = (wr_en && wsel == SEL_SWCLR) ? wr_data[NUM_SW-1:0] : '0;
    end

    // Software request flags.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= (sw_q | set_mask) & ~clr_mask;
    end

    // Current priority and saved copy; acknowledge takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            saved_q <= '0;
        end else if (ack_take) begin
            saved_q <= cur_q;
            cur_q   <= ack_lvl;
        end else if (wr_en && wsel == SEL_CUR) begin
            cur_q <= wr_data[PRIO_W-1:0];
        end else if (wr_en && wsel == SEL_EOI) begin
            cur_q <= saved_q;
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        case (rsel)
            SEL_CUR:   rd_data = DATA_W'(cur_q);
            SEL_EOI:   rd_data = DATA_W'(saved_q);
            SEL_SWSET: rd_data = DATA_W'(sw_q);
            SEL_PRIO:  rd_data = DATA_W'(prio_q[ridx]);
            default:   rd_data = '0;
        endcase
    end

    assign sw_flags = sw_q;
    assign cur_prio = cur_q;

    // R8: an accepted acknowledge loads the served level.
    a_r8_ack_loads_level: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (cur_q == $past(ack_lvl)));
    // R8: the level in force before the acknowledge is kept.
    a_r8_ack_saves_old: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (saved_q == $past(cur_q)));
    // R9: end of interrupt restores the saved level.
    a_r9_eoi_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_EOI && !ack_take) |=> (cur_q == $past(saved_q)));
    // R6: a set write leaves every selected flag high.
    a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask) |=> ((sw_q & $past(set_mask)) == $past(set_mask)));
    // R6: a clear write leaves every selected flag low.
    a_r6_clr_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((sw_q & $past(clr_mask)) == '0));
    // R10: a mask write that collides with an acknowledge is discarded.
    a_r10_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && wr_en && wsel == SEL_CUR) |=> (cur_q == $past(ack_lvl)));

endmodule

// File: rtl/irqc_arb_tree.sv
// Module irqc_arb_tree
// Combinational priority search over all sources. A source qualifies when it
// is pending and its level is strictly above the current priority. Pairs are
// merged level by level; on equal levels the lower-index side is kept, so the
// lowest index wins a tie. Assumes padding leaves beyond NUM_SRC never qualify.
module irqc_arb_tree #(
    parameter int NUM_SRC = 128,
    parameter int PRIO_W  = 4,
    parameter int LVLS    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         cur_prio,
    output logic                      win_vld,
    output logic [PRIO_W-1:0]         win_lvl,
    output logic [LVLS-1:0]           win_idx
);

    localparam int LEAVES = 1 << LVLS;

    logic              c_vld [LEAVES];
    logic [PRIO_W-1:0] c_lvl [LEAVES];
    logic [LVLS-1:0]   c_idx [LEAVES];

    // Fill the leaves, then fold pairs toward slot 0.
    always_comb begin
        for (int i = 0; i < LEAVES; i++) begin
            if (i < NUM_SRC) begin
                c_lvl[i] = prio_flat[i*PRIO_W +: PRIO_W];
                c_vld[i] = pend[i] && (prio_flat[i*PRIO_W +: PRIO_W] > cur_prio);
            end else begin
                c_lvl[i] = '0;
                c_vld[i] = 1'b0;
            end
            c_idx[i] = LVLS'(i);
        end
        for (int lv = 0; lv < LVLS; lv++) begin
            for (int n = 0; n < (LEAVES >> (lv + 1)); n++) begin
                if (c_vld[2*n] && (!c_vld[2*n+1] || c_lvl[2*n] >= c_lvl[2*n+1])) begin
                    c_lvl[n] = c_lvl[2*n];
                    c_idx[n] = c_idx[2*n];
                end else begin
                    c_lvl[n] = c_lvl[2*n+1];
                    c_idx[n] = c_idx[2*n+1];
                end
                c_vld[n] = c_vld[2*n] | c_vld[2*n+1];
            end
        end
        win_vld = c_vld[0];
        win_lvl = c_lvl[0];
        win_idx = c_idx[0];
    end

endmodule

// File: rtl/irqc_out_stage.sv
// Module irqc_out_stage
// Registers the arbitration result toward the processor. Holds the vector at
// zero and the level at zero whenever nothing qualifies. Assumes VEC_W >= LVLS.
module irqc_out_stage #(
    parameter int PRIO_W = 4,
    parameter int LVLS   = 7,
    parameter int VEC_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_vld,
    input  logic [PRIO_W-1:0] win_lvl,
    input  logic [LVLS-1:0]   win_idx,
    input  logic [PRIO_W-1:0] cur_prio,
    output logic              irq_q,
    output logic [PRIO_W-1:0] lvl_q,
    output logic [VEC_W-1:0]  vec_q
);

    // Capture the winner once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            lvl_q <= '0;
            vec_q <= '0;
        end else begin
            irq_q <= win_vld;
            lvl_q <= win_vld ? win_lvl : '0;
            vec_q <= win_vld ? VEC_W'(win_idx) : '0;
        end
    end

    // R2: a presented request never carries level 0.
    a_r2_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (lvl_q != '0));
    // R2: a presented level was above the mask seen when it was chosen.
    a_r2_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |=> (lvl_q > $past(cur_prio)));
    // R4: with no request the vector rests at zero.
    a_r4_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_q |-> (vec_q == '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
// Module irq_prio_ctrl
// Top of the prioritized vectored interrupt controller. Sources 0..NUM_SW-1
// are software flags; hw_req[j] feeds source NUM_SW+j. An acknowledge is
// accepted only while a request is presented. The non-maskable path is a
// direct wire. Assumes NUM_SW < NUM_SRC.
module irq_prio_ctrl #(
    parameter int NUM_SRC = 128,
    parameter int NUM_SW  = 8,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 9,
    parameter int ADDR_W  = 9,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic [NUM_SRC-NUM_SW-1:0] hw_req,
    input  logic                      ack,
    input  logic                      nmi_in,
    output logic                      irq_out,
    output logic [VEC_W-1:0]          vec_out,
    output logic                      nmi_out
);

    localparam int LVLS = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SW-1:0]         sw_flags;
    logic [PRIO_W-1:0]         cur_prio;
    logic [NUM_SRC-1:0]        pend;
    logic                      win_vld;
    logic [PRIO_W-1:0]         win_lvl;
    logic [LVLS-1:0]           win_idx;
    logic                      irq_q;
    logic [PRIO_W-1:0]         lvl_q;
    logic                      ack_take;

    // Gather software and hardware requests into one pending vector.
    assign pend     = {hw_req, sw_flags};
    assign ack_take = ack && irq_q;

    irqc_regs #(
        .NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW), .PRIO_W(PRIO_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ack_take(ack_take), .ack_lvl(lvl_q),
        .prio_flat(prio_flat), .sw_flags(sw_flags), .cur_prio(cur_prio)
    );

    irqc_arb_tree #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .LVLS(LVLS)
    ) u_arb (
        .pend(pend), .prio_flat(prio_flat), .cur_prio(cur_prio),
        .win_vld(win_vld), .win_lvl(win_lvl), .win_idx(win_idx)
    );

    irqc_out_stage #(
        .PRIO_W(PRIO_W), .LVLS(LVLS), .VEC_W(VEC_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n),
        .win_vld(win_vld), .win_lvl(win_lvl), .win_idx(win_idx),
        .cur_prio(cur_prio),
        .irq_q(irq_q), .lvl_q(lvl_q), .vec_q(vec_out)
    );

    assign irq_out = irq_q;
    assign nmi_out = nmi_in;

    // R4: a presented vector always names an existing source.
    a_r4_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (int'(vec_out) < NUM_SRC));
    // R8: after an accepted acknowledge the served source is masked out.
    a_r8_served_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (cur_prio >= $past(lvl_q)));
    // R12: the non-maskable path tracks its input.
    always_comb a_r12_nmi_direct: assert (nmi_out == nmi_in);

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 16;
    localparam int NSW  = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [8:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [8:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  hw_req = '0;
    logic        ack = 0;
    logic        nmi_in = 0;
    logic        irq_out;
    logic [8:0]  vec_out;
    logic        nmi_out;

    int checks = 0;
    int errors = 0;
    int prio_m [NSRC];
    logic [7:0] sw_m = '0;
    int cur_m = 0;

    irq_prio_ctrl #(
        .NUM_SRC(NSRC), .NUM_SW(NSW), .PRIO_W(4), .VEC_W(9), .ADDR_W(9), .DATA_W(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .hw_req(hw_req), .ack(ack),
        .nmi_in(nmi_in), .irq_out(irq_out), .vec_out(vec_out), .nmi_out(nmi_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 9'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = 9'(a);
        #1;
        d = int'(rd_data);
    endtask

    // Expected winner from the requirement: highest level above mask, lowest index on ties.
    task automatic check_out(input string req);
        int best;
        int bl;
        bit p;
        best = -1; bl = 0;
        for (int i = 0; i < NSRC; i++) begin
            p = (i < NSW) ? sw_m[i] : hw_req[i-NSW];
            if (p && prio_m[i] > cur_m && prio_m[i] > bl) begin
                bl = prio_m[i];
                best = i;
            end
        end
        chk(req, int'(irq_out), (best >= 0) ? 1 : 0);
        chk(req, int'(vec_out), (best >= 0) ? best : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 irq", int'(irq_out), 0);
        chk("R1 vec", int'(vec_out), 0);
        rd(0, d); chk("R1 cur", d, 0);
        rd(1, d); chk("R1 saved", d, 0);
        rd(2, d); chk("R1 flags", d, 0);
        rd(256+5, d); chk("R1 prio", d, 0);

        // R11: priority table write and readback
        for (int i = 0; i < NSRC; i++) begin
            prio_m[i] = (i*7 + 3) % 16;
            wr(256+i, prio_m[i]);
        end
        for (int i = 0; i < NSRC; i++) begin
            rd(256+i, d); chk("R11 prio readback", d, prio_m[i]);
        end

        // R3 R4: sweep pending patterns against several masks
        for (int p = 0; p < 256; p++) begin
            hw_req = 8'((p*37) % 256);
            wr(3, 8'hFF);
            wr(2, p);
            sw_m = 8'(p);
            for (int k = 0; k < 4; k++) begin
                cur_m = k*5 - (k == 3 ? 1 : 0);
                wr(0, cur_m);
                step();
                check_out("R3 R4 sweep");
            end
        end

        // R3: ties broken toward the lowest index
        prio_m[3] = 15; prio_m[9] = 15; prio_m[12] = 15;
        wr(256+3, 15); wr(256+9, 15); wr(256+12, 15);
        wr(3, 8'hFF); wr(2, 8'h08); sw_m = 8'h08;
        hw_req = 8'h12;
        cur_m = 0; wr(0, 0);
        step();
        chk("R3 tie", int'(vec_out), 3);
        wr(3, 8'h08); sw_m = 8'h00;
        step();
        chk("R3 tie next", int'(vec_out), 9);
        check_out("R3 tie model");

        // R2: level 0 is never forwarded
        hw_req = 8'h08;
        step(); step();
        chk("R2 level0 irq", int'(irq_out), 0);
        chk("R2 level0 vec", int'(vec_out), 0);

        // R5: one registered stage of latency
        hw_req = 8'h00;
        step(); step();
        hw_req = 8'h10;
        #1;
        chk("R5 before edge", int'(irq_out), 0);
        step();
        chk("R5 after edge", int'(irq_out), 1);
        chk("R5 vec", int'(vec_out), 12);
        wr(0, 15); cur_m = 15;
        chk("R5 write not yet seen", int'(irq_out), 1);
        step();
        chk("R5 write seen", int'(irq_out), 0);

        // R6: software set/clear by mask, zeros ignored
        wr(3, 8'hFF); wr(2, 8'hA5);
        rd(2, d); chk("R6 set", d, 8'hA5);
        wr(3, 8'h05);
        rd(2, d); chk("R6 clear", d, 8'hA0);
        wr(2, 8'h00);
        rd(2, d); chk("R6 zero set", d, 8'hA0);
        wr(3, 8'h00);
        rd(2, d); chk("R6 zero clear", d, 8'hA0);
        wr(3, 8'hFF); sw_m = 8'h00;

        // R7: current priority write and readback
        wr(0, 6);
        rd(0, d); chk("R7 cur", d, 6);

        // R8: acknowledge raises the mask to the served level
        cur_m = 0; wr(0, 0);
        hw_req = 8'h04;
        step(); step();
        chk("R8 present", int'(irq_out), 1);
        chk("R8 vec", int'(vec_out), 10);
        ack = 1; step(); ack = 0;
        rd(0, d); chk("R8 cur after ack", d, 9);
        rd(1, d); chk("R8 saved", d, 0);
        step();
        chk("R8 masked", int'(irq_out), 0);
        ack = 1; step(); ack = 0;
        rd(0, d); chk("R8 idle ack ignored", d, 9);
        wr(2, 8'h10);
        step();
        chk("R8 preempt irq", int'(irq_out), 1);
        chk("R8 preempt vec", int'(vec_out), 4);

        // R9: end of interrupt restores the saved level
        wr(3, 8'h10);
        wr(1, 0);
        rd(0, d); chk("R9 restored", d, 0);
        step();
        chk("R9 irq back", int'(irq_out), 1);
        chk("R9 vec back", int'(vec_out), 10);

        // R10: ack collides with a mask write
        @(negedge clk);
        ack = 1; wr_en = 1; wr_addr = 9'd0; wr_data = 8'd2;
        @(negedge clk);
        ack = 0; wr_en = 0;
        rd(0, d); chk("R10 ack over mask write", d, 9);
        wr(1, 0);
        step();
        chk("R10 irq again", int'(irq_out), 1);
        // R10: ack collides with end of interrupt
        @(negedge clk);
        ack = 1; wr_en = 1; wr_addr = 9'd1; wr_data = 8'd0;
        @(negedge clk);
        ack = 0; wr_en = 0;
        rd(0, d); chk("R10 ack over eoi", d, 9);

        // R12: non-maskable path ignores the mask
        wr(0, 15);
        nmi_in = 1; #1;
        chk("R12 nmi high", int'(nmi_out), 1);
        step();
        nmi_in = 0; #1;
        chk("R12 nmi low", int'(nmi_out), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule